// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the bit phases of an I2C master. A pre-divided source clock arrives as a one-cycle enable, `tick_i`. Two cascaded counters divide it: an inner sample counter and an outer step counter. Each half of an SCL period therefore lasts sample_count × step_count ticks, and the bus frequency is the source clock divided by (pre-divider × 2 × sample_count × step_count). The byte sequencer does not count time itself. It consumes four one-cycle phase strobes: change SDA, raise SCL, sample SDA and lower SCL. It also reads the SCL level and a flag that tells which timing set is in force.

Software programs two 16-bit registers through a plain write port. The normal register times standard and fast mode. The high-speed register carries its own packed sample and step fields and an enable code, and when that code is present its fields replace the normal ones. The sequencer holds `run_i` high for as long as it wants bits. The block samples `run_i` only at bit boundaries, so back-to-back bits follow with no gap. Register writes reach the counters only while the block is idle, never in the middle of a bit.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset `scl_o` is 1, every strobe is 0, `hs_mode_o` is 0, and the timing in force is sample count 1 and step count 1.
- R2: A write with `cfg_sel`=0 stores sample_count−1 from `cfg_wdata[10:8]` and step_count−1 from `cfg_wdata[5:0]`. When high speed is off, each SCL half lasts sample_count × step_count ticks.
- R3: A write with `cfg_sel`=1 stores sample_count−1 from `cfg_wdata[14:12]` and step_count−1 from `cfg_wdata[10:8]`, so the high-speed step count is at most 8. High speed is on only when `cfg_wdata[1:0]` is 3; any other value, including 0, leaves the normal fields in force.
- R4: `scl_o` is 1 while idle. During a bit it is 0 for the first half and 1 for the second half.
- R5: `sda_chg_o` pulses on the first tick of each bit's low half.
- R6: `scl_rise_o` pulses on the first tick of the high half.
- R7: `sda_smp_o` pulses on the first tick of the middle step of the high half, that is at tick H + floor(T/2)×S of the bit, with H = S×T.
- R8: `scl_fall_o` pulses on the last tick of the bit. That tick returns SCL low if another bit follows.
- R9: Cycles with `tick_i`=0 advance nothing and raise no strobe.
- R10: A bit starts in the cycle after `run_i` is seen high while idle. At the end of a bit, `run_i`=1 starts the next bit at once and `run_i`=0 returns the block to idle.
- R11: Register writes take effect only while idle: the set in force is reloaded from the registers on every idle cycle and frozen while a bit is running.
- R12: `hs_mode_o` is 1 exactly when the set in force is the high-speed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 normal timing, 1 high-speed timing |
| cfg_wdata | input | 16 | Register write data |
| tick_i | input | 1 | Pre-divided source clock enable |
| run_i | input | 1 | Sequencer requests bits |
| scl_o | output | 1 | SCL level to drive |
| sda_chg_o | output | 1 | Strobe: SDA may change |
| scl_rise_o | output | 1 | Strobe: release SCL high |
| sda_smp_o | output | 1 | Strobe: sample SDA |
| scl_fall_o | output | 1 | Strobe: last tick of the bit |
| hs_mode_o | output | 1 | High-speed timing set in force |

## Verification
A wrong counter bound or a misread field would make the bit length differ from 2×S×T ticks. This shows as the first rise or fall strobe arriving early or late, within one bit of the start. A shadow set that is not frozen would stretch or shrink the current bit as soon as a write lands during it. A tick leak would move a strobe within a few cycles. A reference model compares every output on every clock, so each of these faults is caught in the cycle where it first appears at the ports. Directed bit-length measurements tie the failure to the field or mode at fault.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
    localparam int REG_W      = 16;
    localparam int SMP_W      = 3;
    localparam int STP_W      = 6;
    localparam int HSTP_W     = 3;
    localparam int NRM_SMP_LO = 8;
    localparam int NRM_STP_LO = 0;
    localparam int HS_SMP_LO  = 12;
    localparam int HS_STP_LO  = 8;
    localparam logic [1:0] HS_ON_CODE = 2'b11;

    typedef struct packed {
        logic             hs;
        logic [SMP_W-1:0] smax;
        logic [STP_W-1:0] tmax;
    } tcfg_t;
endpackage

// File: rtl/i2c_tg_regs.sv
module i2c_tg_regs
    import i2c_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             busy_i,
    output tcfg_t            cfg_o
);
    typedef struct packed {
        logic [SMP_W-1:0]  nrm_smp;
        logic [STP_W-1:0]  nrm_stp;
        logic [SMP_W-1:0]  hs_smp;
        logic [HSTP_W-1:0] hs_stp;
        logic              hs_en;
        tcfg_t             cfg;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        // shadow reload from the programmed values while idle (R11)
        if (!busy_i) begin
            d.cfg.hs = q.hs_en;
            if (q.hs_en) begin
                d.cfg.smax = q.hs_smp;
                d.cfg.tmax = {{(STP_W-HSTP_W){1'b0}}, q.hs_stp};
            end else begin
                d.cfg.smax = q.nrm_smp;
                d.cfg.tmax = q.nrm_stp;
            end
        end
        if (wr_i) begin
            if (!sel_i) begin
                d.nrm_smp = wdata_i[NRM_SMP_LO +: SMP_W];
                d.nrm_stp = wdata_i[NRM_STP_LO +: STP_W];
            end else begin
                d.hs_smp = wdata_i[HS_SMP_LO +: SMP_W];
                d.hs_stp = wdata_i[HS_STP_LO +: HSTP_W];
                d.hs_en  = (wdata_i[1:0] == HS_ON_CODE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_o = q.cfg;

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(q.cfg));
endmodule

// File: rtl/i2c_tg_count.sv
module i2c_tg_count
    import i2c_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [SMP_W-1:0] smax_i,
    input  logic [STP_W-1:0] tmax_i,
    output logic             busy_o,
    output logic             half_o,
    output logic [SMP_W-1:0] samp_o,
    output logic [STP_W-1:0] step_o,
    output logic             bit_end_o
);
    typedef struct packed {
        logic             busy;
        logic             half;
        logic [SMP_W-1:0] samp;
        logic [STP_W-1:0] step;
    } cnt_t;

    cnt_t q, d;
    logic last_s, last_t;

    always_comb begin
        d      = q;
        last_s = (q.samp == smax_i);
        last_t = (q.step == tmax_i);
        bit_end_o = q.busy & tick_i & last_s & last_t & q.half;
        if (!q.busy) begin
            if (run_i) begin
                d.busy = 1'b1;
                d.half = 1'b0;
                d.samp = '0;
                d.step = '0;
            end
        end else if (tick_i) begin
            if (!last_s) begin
                d.samp = q.samp + 1'b1;
            end else begin
                d.samp = '0;
                if (!last_t) begin
                    d.step = q.step + 1'b1;
                end else begin
                    d.step = '0;
                    d.half = ~q.half;
                    if (q.half && !run_i) d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign half_o = q.half;
    assign samp_o = q.samp;
    assign step_o = q.step;

    p_samp_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.samp <= smax_i && q.step <= tmax_i));
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick_i) |=> ($stable(q.samp) && $stable(q.step) && $stable(q.half) && q.busy));
    p_bit_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_o |=> (!q.half && q.samp == '0 && q.step == '0));
endmodule

// File: rtl/i2c_tg_strobe.sv
module i2c_tg_strobe
    import i2c_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             half_i,
    input  logic [SMP_W-1:0] samp_i,
    input  logic [STP_W-1:0] step_i,
    input  logic [STP_W-1:0] tmax_i,
    input  logic             tick_i,
    input  logic             bit_end_i,
    output logic             scl_o,
    output logic             sda_chg_o,
    output logic             scl_rise_o,
    output logic             sda_smp_o,
    output logic             scl_fall_o
);
    localparam int MID_W = STP_W + 1;

    logic             live;
    logic             at_step0;
    logic [MID_W-1:0] mid_step;

    always_comb begin
        live       = busy_i & tick_i;
        at_step0   = (step_i == '0) && (samp_i == '0);
        mid_step   = ({1'b0, tmax_i} + 1'b1) >> 1;
        sda_chg_o  = live & ~half_i & at_step0;
        scl_rise_o = live &  half_i & at_step0;
        sda_smp_o  = live &  half_i & (samp_i == '0) & ({1'b0, step_i} == mid_step);
        scl_fall_o = bit_end_i;
        scl_o      = ~busy_i | half_i;
    end

    p_low_high_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_chg_o, scl_rise_o}));
    p_fall_in_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |-> scl_o);
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             tick_i,
    input  logic             run_i,
    output logic             scl_o,
    output logic             sda_chg_o,
    output logic             scl_rise_o,
    output logic             sda_smp_o,
    output logic             scl_fall_o,
    output logic             hs_mode_o
);
    tcfg_t            cfg;
    logic             busy, half, bit_end;
    logic [SMP_W-1:0] samp;
    logic [STP_W-1:0] step;

    i2c_tg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .sel_i(cfg_sel),
        .wdata_i(cfg_wdata), .busy_i(busy), .cfg_o(cfg)
    );

    i2c_tg_count u_count (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .smax_i(cfg.smax), .tmax_i(cfg.tmax), .busy_o(busy), .half_o(half),
        .samp_o(samp), .step_o(step), .bit_end_o(bit_end)
    );

    i2c_tg_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .half_i(half),
        .samp_i(samp), .step_i(step), .tmax_i(cfg.tmax), .tick_i(tick_i),
        .bit_end_i(bit_end), .scl_o(scl_o), .sda_chg_o(sda_chg_o),
        .scl_rise_o(scl_rise_o), .sda_smp_o(sda_smp_o), .scl_fall_o(scl_fall_o)
    );

    assign hs_mode_o = cfg.hs;

    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sda_chg_o || scl_rise_o || sda_smp_o || scl_fall_o));
endmodule

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic cfg_wr = 0, cfg_sel = 0, tick = 0, run = 0;
    logic [15:0] cfg_wdata = '0;
    logic scl, chg, rise, smp, fall, hsm;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    i2c_scl_timer u_i2c_scl_timer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tick_i(tick), .run_i(run), .scl_o(scl),
        .sda_chg_o(chg), .scl_rise_o(rise), .sda_smp_o(smp),
        .scl_fall_o(fall), .hs_mode_o(hsm)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    int m_nrm = 0, m_hsr = 0, c_s = 1, c_t = 1, c_hs = 0, m_busy = 0, m_k = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_nrm = 0; m_hsr = 0; c_s = 1; c_t = 1; c_hs = 0; m_busy = 0; m_k = 0;
        end else begin
            int nb, nk;
            nb = m_busy; nk = m_k;
            if (m_busy == 0) begin
                if (run) begin nb = 1; nk = 0; end
            end else if (tick) begin
                nk = m_k + 1;
                if (nk == 2 * c_s * c_t) begin
                    nk = 0;
                    if (!run) nb = 0;
                end
            end
            if (m_busy == 0) begin
                c_hs = ((m_hsr & 3) == 3) ? 1 : 0;
                if (c_hs == 1) begin
                    c_s = ((m_hsr >> 12) & 7) + 1;
                    c_t = ((m_hsr >> 8) & 7) + 1;
                end else begin
                    c_s = ((m_nrm >> 8) & 7) + 1;
                    c_t = (m_nrm & 63) + 1;
                end
            end
            if (cfg_wr) begin
                if (cfg_sel) m_hsr = cfg_wdata;
                else         m_nrm = cfg_wdata;
            end
            m_busy = nb; m_k = nk;
        end
        if (cyc > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int h;
            bit lv;
            h  = c_s * c_t;
            lv = (m_busy == 1) && tick;
            check(scl  == ((m_busy == 0) || (m_k >= h)), "R4 scl level", scl, 1);
            check(chg  == (lv && m_k == 0), "R5 sda_chg", chg, lv && m_k == 0);
            check(rise == (lv && m_k == h), "R6 scl_rise", rise, lv && m_k == h);
            check(smp  == (lv && m_k == h + (c_t / 2) * c_s), "R7 sda_smp", smp, lv && m_k == h + (c_t / 2) * c_s);
            check(fall == (lv && m_k == 2 * h - 1), "R8 scl_fall", fall, lv && m_k == 2 * h - 1);
            check(hsm  == (c_hs == 1), "R12 hs_mode", hsm, c_hs);
        end
    end

    task automatic wr(input logic sel, input logic [15:0] d);
        @(posedge clk); #1 cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1 cfg_wr = 0;
    endtask

    // one bit with tick held high; optional write landing while busy; returns half length
    task automatic run_bit(output int half_len, input bit do_wr, input logic sel, input logic [15:0] d);
        int n;
        n = 0;
        @(posedge clk); #1 run = 1;
        @(posedge clk); #1 run = 0;
        if (do_wr) begin cfg_wr = 1; cfg_sel = sel; cfg_wdata = d; end
        forever begin
            @(negedge clk);
            n++;
            if (n == 2) cfg_wr = 0;
            if (fall) break;
        end
        half_len = n / 2;
        @(posedge clk); @(posedge clk); #1;
    endtask

    initial begin
        int h, falls, bad;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(scl == 1 && !chg && !rise && !smp && !fall && !hsm, "R1 reset outputs", {scl, chg, rise, smp, fall, hsm}, 32);
        #1 rst_n = 1;
        tick = 1;
        run_bit(h, 0, 0, 0);
        check(h == 1, "R1 reset timing half", h, 1);

        wr(0, 16'h0203);
        run_bit(h, 0, 0, 0);
        check(h == 12, "R2 normal S3 T4", h, 12);
        wr(0, 16'h073F);
        run_bit(h, 0, 0, 0);
        check(h == 512, "R2 normal S8 T64", h, 512);

        wr(1, 16'h5703);
        run_bit(h, 0, 0, 0);
        check(h == 48, "R3 hs S6 T8", h, 48);
        check(hsm == 1, "R12 hs flag on", hsm, 1);
        wr(1, 16'h5702);
        wr(0, 16'h0102);
        run_bit(h, 0, 0, 0);
        check(h == 6, "R3 hs code not 3 keeps normal", h, 6);
        check(hsm == 0, "R12 hs flag off", hsm, 0);
        wr(1, 16'h0000);

        // R11: write during a busy bit is deferred
        wr(0, 16'h0101);
        run_bit(h, 1, 0, 16'h0305);
        check(h == 4, "R11 busy write deferred", h, 4);
        run_bit(h, 0, 0, 0);
        check(h == 24, "R11 idle write applied", h, 24);

        // R9: no tick, no progress
        wr(0, 16'h0102);
        tick = 0;
        @(posedge clk); #1 run = 1;
        @(posedge clk); #1 run = 0;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (chg || rise || smp || fall || scl) bad++;
        end
        check(bad == 0, "R9 frozen without tick", bad, 0);
        tick = 1;
        @(negedge clk); while (!fall) @(negedge clk);
        @(posedge clk); #1;

        // R10: three back-to-back bits
        falls = 0; h = 0;
        @(posedge clk); #1 run = 1;
        while (h < 3) begin
            @(negedge clk);
            if (chg) h++;
            if (fall) falls++;
        end
        run = 0;
        while (falls < 3) begin
            @(negedge clk);
            if (fall) falls++;
        end
        bad = 0;
        repeat (15) begin
            @(negedge clk);
            if (chg || !scl) bad++;
        end
        check(falls == 3 && bad == 0, "R10 run held three bits then idle", falls * 100 + bad, 300);

        // mixed stimulus against the model
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk); #1;
            tick   = ($urandom_range(0, 1) == 1);
            run    = ($urandom_range(0, 3) != 0);
            cfg_wr = ($urandom_range(0, 40) == 0);
            cfg_sel = $urandom_range(0, 1);
            cfg_wdata = $urandom_range(0, 65535) & 16'h7703 | 16'h0000;
            if (!cfg_sel) cfg_wdata = $urandom_range(0, 65535) & 16'h0707;
        end
        @(posedge clk); #1 cfg_wr = 0; run = 0;
        repeat (5) @(posedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule